// File: doc/BRIEF.md
# Brute-Force Stream-Cipher Key Search Controller

This block recovers the 24-bit key of a short message that was encrypted with the RC4 stream cipher. The 32-byte ciphertext is held on an input bus. The block tries candidate keys one after another. For each key it fills its working permutation with the identity, mixes the permutation with the key, and then generates keystream bytes. Each keystream byte is XORed with the matching ciphertext byte to give a candidate plaintext byte. The plaintext is assumed to contain only lowercase letters and spaces. A candidate key is dropped as soon as it produces one byte outside that set, and the next key is tried.

The key space is divided among several identical cores that run side by side. With N cores, core c tests keys c, c+N, c+2N and so on. When any core finds a key that decodes the whole message to plausible text, every core stops. The block then holds the winning key and its plaintext for as long as it stays out of reset. If all cores run out of keys without a match, a separate exhaustion flag is raised instead. The key under test is always visible for a six-digit hex display.

Top module: `rc4_key_search`

## Requirements
- R1: A decrypted byte is plausible only if its value is 32 (space) or lies between 97 and 122 inclusive (lowercase a to z). Values 96 and 123 are not plausible.
- R2: A key is accepted only when all 32 decrypted bytes are plausible. A single implausible byte at any position, including the first or the last, rejects the key.
- R3: Decryption follows RC4. Key byte 0 is key[23:16], byte 1 is key[15:8] and byte 2 is key[7:0], used cyclically in the mixing loop. Ciphertext byte k sits at cipher_text[8k+7:8k], and plaintext byte k sits at plain_text[8k+7:8k].
- R4: Only keys 0 to KEY_MAX are tested (the default KEY_MAX is 0x3FFFFF, so the top two key bits are zero). With NCORES cores, core c tests only keys congruent to c modulo NCORES. cur_key never exceeds KEY_MAX.
- R5: When a key is accepted, found rises and stays high. From then on, cur_key holds the accepted key, plain_text holds its decrypted message, and neither changes until reset.
- R6: exhausted rises only when every core has rejected all of its keys, and it then stays high. found and exhausted are never high together.
- R7: While the search runs, cur_key shows the key being tested by core 0, which is always a multiple of NCORES.
- R8: During and immediately after reset, found and exhausted are low and cur_key is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts the search |
| cipher_text | input | MSG_LEN*8 | Encrypted message, byte k at bits 8k+7:8k |
| plain_text | output | MSG_LEN*8 | Decrypted message of the accepted key, valid while found is high |
| cur_key | output | KEY_W | Key under test, or the accepted key once found |
| found | output | 1 | A key has been accepted |
| exhausted | output | 1 | All keys were rejected |

## Verification
The embedded assertions check on every cycle that found and exhausted are never high together and that each flag is sticky. They also check that the held key and plaintext stay frozen after success, that every byte of a reported plaintext is plausible, and that each core's key stays in its own residue class and within KEY_MAX. Some behaviours can only be shown by the bench's scenarios: the bench encrypts known messages under chosen keys and checks that the correct key is recovered, that byte boundaries at 96, 97, 122 and 123 are handled, and that a single bad byte at the first, middle or last position leads to exhaustion rather than a false match. These scenarios use a reduced key space.

// File: rtl/rc4_key_search.sv
module rc4_key_search #(
  parameter int          NCORES  = 2,
  parameter int          KEY_W   = 24,
  parameter int unsigned KEY_MAX = 32'h3F_FFFF,
  parameter int          MSG_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MSG_LEN*8-1:0]   cipher_text,
  output logic [MSG_LEN*8-1:0]   plain_text,
  output logic [KEY_W-1:0]       cur_key,
  output logic                   found,
  output logic                   exhausted
);
  localparam int KBYTES = KEY_W / 8;
  localparam int KIW    = (KBYTES > 1) ? $clog2(KBYTES) : 1;
  localparam int CW     = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;
  localparam int IW     = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int MB     = MSG_LEN * 8;

  typedef enum logic [2:0] {S_FILL, S_MIX, S_STEP, S_EMIT, S_WIN, S_EMPTY, S_HALT} st_t;

  function automatic logic plausible(input logic [7:0] b);
    return (b == 8'd32) || (b >= 8'd97 && b <= 8'd122);
  endfunction

  function automatic logic all_plausible(input logic [MB-1:0] m);
    logic r;
    r = 1'b1;
    for (int n = 0; n < MSG_LEN; n++) r &= plausible(m[8*n +: 8]);
    return r;
  endfunction

  logic [NCORES-1:0]       hit, dry;
  logic [NCORES*KEY_W-1:0] keys_flat;
  logic [NCORES*MB-1:0]    text_flat;
  logic                    any_hit;
  logic [IW-1:0]           first_hit, win;

  assign any_hit = |hit;

  always_comb begin
    first_hit = '0;
    for (int c = NCORES - 1; c >= 0; c--)
      if (hit[c]) first_hit = IW'(c);
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [7:0]       sbox [256];
    logic [7:0]       pbuf [MSG_LEN];
    st_t              st;
    logic [7:0]       ii, jj;
    logic [KEY_W-1:0] key;
    logic [KIW-1:0]   kidx;
    logic [CW-1:0]    kcnt;
    logic [7:0]       kb, jn_mix, ip, jn_step, fval, pbyte;
    logic             ok, last_key;

    assign kb       = key[(KEY_W - 1 - 8 * kidx) -: 8];
    assign jn_mix   = jj + sbox[ii] + kb;
    assign ip       = ii + 8'd1;
    assign jn_step  = jj + sbox[ip];
    assign fval     = sbox[8'(sbox[ii] + sbox[jj])];
    assign pbyte    = fval ^ cipher_text[8*kcnt +: 8];
    assign ok       = plausible(pbyte);
    assign last_key = (33'(key) + 33'(NCORES)) > 33'(KEY_MAX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= S_FILL;
        ii   <= '0;
        jj   <= '0;
        kidx <= '0;
        kcnt <= '0;
        key  <= KEY_W'(c);
      end else if (any_hit && (st == S_FILL || st == S_MIX || st == S_STEP || st == S_EMIT)) begin
        st <= S_HALT;
      end else begin
        case (st)
          S_FILL: begin
            ii <= ii + 8'd1;
            if (ii == 8'd255) begin
              st   <= S_MIX;
              jj   <= '0;
              kidx <= '0;
            end
          end
          S_MIX: begin
            jj   <= jn_mix;
            ii   <= ii + 8'd1;
            kidx <= (kidx == KIW'(KBYTES - 1)) ? '0 : kidx + 1'b1;
            if (ii == 8'd255) begin
              st   <= S_STEP;
              jj   <= '0;
              kcnt <= '0;
            end
          end
          S_STEP: begin
            ii <= ip;
            jj <= jn_step;
            st <= S_EMIT;
          end
          S_EMIT: begin
            if (ok) begin
              if (kcnt == CW'(MSG_LEN - 1)) st <= S_WIN;
              else begin
                kcnt <= kcnt + 1'b1;
                st   <= S_STEP;
              end
            end else if (last_key) begin
              st <= S_EMPTY;
            end else begin
              key <= key + KEY_W'(NCORES);
              ii  <= '0;
              st  <= S_FILL;
            end
          end
          default: st <= st;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      case (st)
        S_FILL: sbox[ii] <= ii;
        S_MIX: begin
          sbox[ii]     <= sbox[jn_mix];
          sbox[jn_mix] <= sbox[ii];
        end
        S_STEP: begin
          sbox[ip]      <= sbox[jn_step];
          sbox[jn_step] <= sbox[ip];
        end
        S_EMIT: if (ok) pbuf[kcnt] <= pbyte;
        default: ;
      endcase
    end

    assign hit[c] = (st == S_WIN);
    assign dry[c] = (st == S_EMPTY);
    assign keys_flat[c*KEY_W +: KEY_W] = key;
    for (genvar n = 0; n < MSG_LEN; n++) begin : g_byte
      assign text_flat[c*MB + 8*n +: 8] = pbuf[n];
    end

    a_r4_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(key) % NCORES) == c);
    a_r4_core_range: assert property (@(posedge clk) disable iff (!rst_n)
      33'(key) <= 33'(KEY_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found     <= 1'b0;
      exhausted <= 1'b0;
      win       <= '0;
    end else begin
      if (any_hit && !found) begin
        found <= 1'b1;
        win   <= first_hit;
      end
      if (&dry && !any_hit && !found) exhausted <= 1'b1;
    end
  end

  assign cur_key    = found ? keys_flat[win*KEY_W +: KEY_W] : keys_flat[KEY_W-1:0];
  assign plain_text = text_flat[win*MB +: MB];

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && exhausted));
  a_r5_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> found);
  a_r6_exhausted_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |=> exhausted);
  a_r5_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> $stable(cur_key));
  a_r5_text_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> $stable(plain_text));
  a_r2_text_plausible: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> all_plausible(plain_text));
  a_r7_core0_shown: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (int'(cur_key) % NCORES) == 0);
  a_r4_key_range: assert property (@(posedge clk) disable iff (!rst_n)
    33'(cur_key) <= 33'(KEY_MAX));
endmodule

// File: tb/sim_rc4_key_search.sv
module sim_rc4_key_search;
  localparam int NC   = 2;
  localparam int KMAX = 23;
  localparam int NV   = 8;

  localparam int VKEY [NV] = '{5, 18, 23, 0, 7, 12, 20, 9};
  localparam int VVAR [NV] = '{0, 4, 0, 0, 1, 2, 3, 5};
  localparam bit VEXP [NV] = '{1, 1, 1, 1, 0, 0, 0, 0};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] cipher_text = '0;
  logic [255:0] plain_text;
  logic [23:0]  cur_key;
  logic         found, exhausted;

  int  tests = 0;
  int  fails = 0;
  bit  ended = 1'b0;

  always #10 clk = ~clk;

  rc4_key_search #(.NCORES(NC), .KEY_W(24), .KEY_MAX(KMAX), .MSG_LEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cipher_text(cipher_text), .plain_text(plain_text),
    .cur_key(cur_key), .found(found), .exhausted(exhausted));

  task automatic check(input bit cond, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] message(input int variant);
    logic [255:0] s, m;
    s = "the quick brown fox jumps over a";
    for (int n = 0; n < 32; n++) m[8*n +: 8] = s[255-8*n -: 8];
    case (variant)
      1: m[255:248] = 8'd123;
      2: m[7:0]     = 8'd96;
      3: m[127:120] = 8'd65;
      4: begin m[7:0] = 8'd122; m[15:8] = 8'd32; m[23:16] = 8'd97; end
      5: m[7:0]     = 8'd64;
      default: ;
    endcase
    return m;
  endfunction

  function automatic logic [255:0] rc4(input logic [23:0] k, input logic [255:0] m);
    logic [7:0] s [256];
    logic [7:0] kb [3];
    logic [7:0] i, j, t;
    logic [255:0] r;
    kb[0] = k[23:16]; kb[1] = k[15:8]; kb[2] = k[7:0];
    for (int n = 0; n < 256; n++) s[n] = 8'(n);
    j = 0;
    for (int n = 0; n < 256; n++) begin
      j = j + s[n] + kb[n % 3];
      t = s[n]; s[n] = s[j]; s[j] = t;
    end
    i = 0; j = 0;
    for (int n = 0; n < 32; n++) begin
      i = i + 1;
      j = j + s[i];
      t = s[i]; s[i] = s[j]; s[j] = t;
      r[8*n +: 8] = s[8'(s[i] + s[j])] ^ m[8*n +: 8];
    end
    return r;
  endfunction

  initial begin
    for (int v = 0; v < NV; v++) begin
      logic [255:0] msg;
      logic [23:0]  held;
      int           waited;
      msg = message(VVAR[v]);
      @(negedge clk);
      rst_n = 1'b0;
      cipher_text = rc4(24'(VKEY[v]), msg);
      repeat (3) @(negedge clk);
      check(!found && !exhausted && cur_key == 0, "R8 during reset",
            {found, exhausted, cur_key}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!found && !exhausted && cur_key == 0, "R8 after reset",
            {found, exhausted, cur_key}, 0);
      repeat (700) @(negedge clk);
      if (!found && !exhausted)
        check(cur_key % NC == 0 && cur_key <= KMAX, "R7 key shown mid-search",
              cur_key, 0);
      waited = 0;
      while (!found && !exhausted && waited < 30000) begin
        @(negedge clk);
        waited++;
      end
      if (VEXP[v]) begin
        check(found && !exhausted, "R1 R3 key accepted", {found, exhausted}, 2'b10);
        check(cur_key == 24'(VKEY[v]), "R3 R4 recovered key", cur_key, VKEY[v]);
        check(plain_text == msg, "R3 decrypted text", plain_text, msg);
        held = cur_key;
        repeat (60) @(negedge clk);
        check(found && cur_key == held && plain_text == msg && !exhausted,
              "R5 result held", cur_key, held);
      end else begin
        check(exhausted && !found, "R1 R2 R6 key rejected, space exhausted",
              {found, exhausted}, 2'b01);
        repeat (20) @(negedge clk);
        check(exhausted && !found, "R6 exhausted held", {found, exhausted}, 2'b01);
      end
    end
    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!ended) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule